// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block produces the reset for a microprocessor. It merges three sources into one stretched reset pulse. The first is a power-good flag from an external voltage comparator, already synchronized to the block clock. The second is an active-low manual reset line from a pushbutton or from logic. The third is a watchdog that expects regular falling edges on a strobe line. The reset is driven on two registered outputs, one active high and one active low, and the two are always complementary.

All timing comes from a shared one-millisecond tick. A prescaler derives that tick from the clock-frequency parameter. A simulation can set a low clock frequency so that the millisecond intervals take few cycles. When a source ends, the reset stays asserted for a fixed stretch of 250 ticks. The manual input must stay low for 10 consecutive ticks before it counts. A single high sample restarts that count, so very short pulses are ignored and long presses are always seen.

The watchdog timeout is picked by a two-bit select input. While reset is asserted the watchdog counter is cleared and held. It counts from zero again once reset releases. The manual input and the strobe each pass through a two-flop synchronizer before any level or edge is detected.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_good_i` is low, both reset outputs are active from the first clock edge after the low level is sampled (`rst_o` = 1, `rst_n_o` = 0).
- R2: Reset is active out of the asynchronous reset. After the last active reset source goes away, reset stays active for 250 ms (between 249 and 250 tick periods, plus a few cycles of synchronizer latency) and then releases.
- R3: Once `mr_n_i` has been low for 10 consecutive ticks, reset is active. It stays active for as long as `mr_n_i` remains low and is then stretched as in R2.
- R4: A low pulse on `mr_n_i` shorter than 1 ms has no effect on the outputs. A single high sample restarts the low-time count. Any low pulse of 20 ms or longer always causes a reset.
- R5: The watchdog counter restarts only on a high-to-low transition of `wd_strobe_i`. A rising edge or a steady level leaves the timeout where it was.
- R6: The watchdog timeout follows `wd_sel_i`: 2'b00 gives 150 ms, 2'b01 gives 600 ms, 2'b10 gives 1200 ms, and the spare code 2'b11 also gives 1200 ms.
- R7: When no falling edge reaches the strobe within the selected timeout, reset goes active and is held for the 250 ms stretch.
- R8: The watchdog counter is held at zero while reset is active. After release, a fresh full timeout passes before the next watchdog reset.
- R9: `rst_n_o` is the exact complement of `rst_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low reset of the supervisor itself |
| pwr_good_i | input | 1 | Synchronized supply-good flag, low when the supply is below threshold |
| mr_n_i | input | 1 | Manual reset request, active low, asynchronous |
| wd_strobe_i | input | 1 | Watchdog strobe, asynchronous; falling edges restart the timer |
| wd_sel_i | input | 2 | Watchdog timeout select code |
| rst_o | output | 1 | Reset, active high, registered |
| rst_n_o | output | 1 | Reset, active low, registered complement of `rst_o` |

## Verification
Two conditions are the hardest to reach from the ports. One is a rising strobe edge that fails to postpone an expiry. The other is a watchdog that must not carry a count across a reset. The bench stops the background strobe toggler and places single falling and rising edges at known cycle offsets. It then measures, in cycles, how long it takes until reset asserts. It also times the interval from one watchdog reset's release to the next expiry. A counter that kept running during the stretch would make that interval far shorter than a full timeout. Each of the four select codes is swept, and each measured time is compared against a window computed from the tick period.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

  typedef enum logic [1:0] {
    WD_SHORT = 2'b00,
    WD_MID   = 2'b01,
    WD_LONG  = 2'b10,
    WD_SPARE = 2'b11
  } wd_sel_e;

  // Timeout in ticks for a select code; the spare code maps to the longest.
  function automatic int unsigned wd_limit(input wd_sel_e sel,
                                           input int unsigned t_short,
                                           input int unsigned t_mid,
                                           input int unsigned t_long);
    case (sel)
      WD_SHORT: return t_short;
      WD_MID:   return t_mid;
      default:  return t_long;
    endcase
  endfunction

endpackage

// File: rtl/ms_tick_gen.sv
module ms_tick_gen #(
  parameter int unsigned CYC_PER_MS = 50_000
) (
  input  logic clk,
  input  logic arst_n,
  output logic tick_o
);
  generate
    if (CYC_PER_MS <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned W = $clog2(CYC_PER_MS);
      logic [W-1:0] cnt_q;

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)                         cnt_q <= '0;
        else if (cnt_q == W'(CYC_PER_MS - 1)) cnt_q <= '0;
        else                                 cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = (cnt_q == W'(CYC_PER_MS - 1));

      // Ticks are single-cycle pulses separated by idle cycles.
      p_tick_spacing_r2: assert property (@(posedge clk) disable iff (!arst_n)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/pb_qualifier.sv
module pb_qualifier #(
  parameter int unsigned QUAL_MS = 10
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic mr_n_i,
  output logic hit_o
);
  localparam int unsigned QW = $clog2(QUAL_MS + 1);

  logic         s1_q, s2_q;
  logic [QW-1:0] low_cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= mr_n_i;
      s2_q <= s1_q;
    end
  end

  // Low-time counter in ticks; any high sample restarts it, saturates at QUAL_MS.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)                                        low_cnt_q <= '0;
    else if (s2_q)                                      low_cnt_q <= '0;
    else if (tick_i && (low_cnt_q != QW'(QUAL_MS)))     low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign hit_o = (low_cnt_q == QW'(QUAL_MS));

  // A high sample on the synchronized line withdraws the request next cycle.
  p_high_restarts_r4: assert property (@(posedge clk) disable iff (!arst_n)
    s2_q |=> !hit_o);
endmodule

// File: rtl/wd_monitor.sv
module wd_monitor
  import rsup_pkg::*;
#(
  parameter int unsigned T_SHORT_MS = 150,
  parameter int unsigned T_MID_MS   = 600,
  parameter int unsigned T_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       tick_i,
  input  logic       hold_i,
  input  logic       strobe_i,
  input  logic [1:0] sel_i,
  output logic       expire_o
);
  localparam int unsigned T_MAX = (T_LONG_MS > T_MID_MS) ?
    ((T_LONG_MS > T_SHORT_MS) ? T_LONG_MS : T_SHORT_MS) :
    ((T_MID_MS > T_SHORT_MS) ? T_MID_MS : T_SHORT_MS);
  localparam int unsigned LW = $clog2(T_MAX + 1);

  logic          s1_q, s2_q, s3_q;
  logic          fall;
  logic [LW-1:0] limit;
  logic [LW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= strobe_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall  = s3_q & ~s2_q;
  assign limit = LW'(wd_limit(wd_sel_e'(sel_i), T_SHORT_MS, T_MID_MS, T_LONG_MS));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (hold_i || fall) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else if (tick_i && (cnt_q >= limit - 1'b1)) begin
      cnt_q    <= '0;
      expire_o <= 1'b1;
    end else begin
      expire_o <= 1'b0;
      if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  // No expiry can follow a cycle in which reset held the counter.
  p_quiet_in_hold_r8: assert property (@(posedge clk) disable iff (!arst_n)
    hold_i |=> !expire_o);
  // A falling strobe edge restarts the window, so no expiry follows it.
  p_edge_restarts_r5: assert property (@(posedge clk) disable iff (!arst_n)
    fall |=> !expire_o);
  // Expiry is a single-cycle event.
  p_single_expire_r7: assert property (@(posedge clk) disable iff (!arst_n)
    expire_o |=> !expire_o);
endmodule

// File: rtl/reset_stretcher.sv
module reset_stretcher #(
  parameter int unsigned STRETCH_MS = 250
) (
  input  logic clk,
  input  logic arst_n,
  input  logic tick_i,
  input  logic trig_i,
  output logic rst_o,
  output logic rst_n_o
);
  localparam int unsigned SW = $clog2(STRETCH_MS + 1);

  logic          active_d;
  logic [SW-1:0] cnt_q, cnt_d;

  always_comb begin
    active_d = rst_o;
    cnt_d    = cnt_q;
    if (trig_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (rst_o && tick_i) begin
      if (cnt_q == SW'(STRETCH_MS - 1)) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= '0;
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_o   <= active_d;
      rst_n_o <= ~active_d;
    end
  end

  // Any active source asserts reset on the next edge.
  p_trigger_asserts_r1: assert property (@(posedge clk) disable iff (!arst_n)
    trig_i |=> rst_o);
  // Release only happens after a cycle with no active source.
  p_quiet_release_r2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_o) |-> $past(!trig_i));
  // The two outputs never agree.
  p_complement_r9: assert property (@(posedge clk) disable iff (!arst_n)
    rst_o != rst_n_o);
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned STRETCH_MS = 250,
  parameter int unsigned QUAL_MS    = 10,
  parameter int unsigned T_SHORT_MS = 150,
  parameter int unsigned T_MID_MS   = 600,
  parameter int unsigned T_LONG_MS  = 1200
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pwr_good_i,
  input  logic       mr_n_i,
  input  logic       wd_strobe_i,
  input  logic [1:0] wd_sel_i,
  output logic       rst_o,
  output logic       rst_n_o
);
  localparam int unsigned CYC_PER_MS = (CLK_HZ >= 1000) ? (CLK_HZ / 1000) : 1;

  logic tick;
  logic mr_hit;
  logic wd_expire;
  logic trig;

  ms_tick_gen #(.CYC_PER_MS(CYC_PER_MS)) u_tick (
    .clk    (clk),
    .arst_n (arst_n),
    .tick_o (tick)
  );

  pb_qualifier #(.QUAL_MS(QUAL_MS)) u_pb (
    .clk    (clk),
    .arst_n (arst_n),
    .tick_i (tick),
    .mr_n_i (mr_n_i),
    .hit_o  (mr_hit)
  );

  wd_monitor #(
    .T_SHORT_MS (T_SHORT_MS),
    .T_MID_MS   (T_MID_MS),
    .T_LONG_MS  (T_LONG_MS)
  ) u_wd (
    .clk      (clk),
    .arst_n   (arst_n),
    .tick_i   (tick),
    .hold_i   (rst_o),
    .strobe_i (wd_strobe_i),
    .sel_i    (wd_sel_i),
    .expire_o (wd_expire)
  );

  assign trig = ~pwr_good_i | mr_hit | wd_expire;

  reset_stretcher #(.STRETCH_MS(STRETCH_MS)) u_stretch (
    .clk     (clk),
    .arst_n  (arst_n),
    .tick_i  (tick),
    .trig_i  (trig),
    .rst_o   (rst_o),
    .rst_n_o (rst_n_o)
  );
endmodule

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;
  localparam int C  = 4;        // cycles per ms with CLK_HZ = 4000
  localparam int S  = 250;
  localparam int LA = 150;
  localparam int LB = 600;
  localparam int LC = 1200;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic pwr_good = 1'b1;
  logic mr_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic kick_en = 1'b1;
  logic kick_s = 1'b0;
  logic man_s = 1'b0;
  logic strobe;
  logic rst_o, rst_n_o;

  int checks = 0;
  int fails = 0;
  int mism = 0;
  bit done = 1'b0;

  assign strobe = kick_en ? kick_s : man_s;

  always #2.5 clk = ~clk;

  rst_supervisor #(.CLK_HZ(4000)) dut (
    .clk(clk), .arst_n(arst_n), .pwr_good_i(pwr_good), .mr_n_i(mr_n),
    .wd_strobe_i(strobe), .wd_sel_i(sel), .rst_o(rst_o), .rst_n_o(rst_n_o)
  );

  // Background strobe toggler: a falling edge every 40 ms.
  initial forever begin
    repeat (80) @(negedge clk);
    kick_s = ~kick_s;
  end

  // R9 monitor: complement checked every cycle.
  always @(negedge clk) if (arst_n && (rst_n_o !== ~rst_o)) mism++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int v, input int lo, input int hi);
    checks++;
    if (v < lo || v > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, v, lo, hi);
    end
  endtask

  task automatic count_while(input logic lvl, input int limit, output int n);
    n = 0;
    while (rst_o === lvl && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic kick_off();
    @(negedge clk);
    man_s = kick_s;
    kick_en = 1'b0;
  endtask

  task automatic falling();
    man_s = 1'b1;
    repeat (4) @(negedge clk);
    man_s = 1'b0;
  endtask

  task automatic observe_quiet(input string req, input int cyc);
    int bad = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rst_o !== 1'b0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    int lim;
    repeat (3) @(negedge clk);
    // R2: reset state
    check(rst_o === 1'b1 && rst_n_o === 1'b0, "R2 reset state", rst_o, 1);
    arst_n = 1'b1;
    count_while(1'b1, 2000, n);
    check_rng("R2 power-on stretch", n, (S-1)*C, S*C+8);

    // R1: supply drops of several lengths
    foreach (lim_arr[k]) begin end
    for (int k = 0; k < 3; k++) begin
      int w = (k == 0) ? 1 : (k == 1) ? 3 : 50;
      @(negedge clk);
      pwr_good = 1'b0;
      @(negedge clk);
      check(rst_o === 1'b1 && rst_n_o === 1'b0, "R1 assert on supply low", rst_o, 1);
      repeat (w - 1) @(negedge clk);
      pwr_good = 1'b1;
      count_while(1'b1, 2000, n);
      check_rng("R2 stretch after supply return", n, (S-1)*C, S*C+8);
    end

    // R4: short pulses ignored
    for (int w = 1; w <= 3; w++) begin
      @(negedge clk);
      mr_n = 1'b0;
      repeat (w) @(negedge clk);
      mr_n = 1'b1;
      observe_quiet("R4 short pulse ignored", 15*C);
    end
    // R4: single high sample restarts the low-time count
    @(negedge clk);
    mr_n = 1'b0;
    repeat (8*C) @(negedge clk);
    mr_n = 1'b1;
    @(negedge clk);
    mr_n = 1'b0;
    repeat (8*C) @(negedge clk);
    mr_n = 1'b1;
    observe_quiet("R4 high sample restarts count", 15*C);

    // R3/R4: long presses recognised
    for (int k = 0; k < 3; k++) begin
      int wms = (k == 0) ? 20 : (k == 1) ? 25 : 300;
      @(negedge clk);
      mr_n = 1'b0;
      repeat (wms*C - 1) @(negedge clk);
      check(rst_o === 1'b1, (k == 2) ? "R3 held while pressed" : "R4 20ms press recognised",
            rst_o, 1);
      @(negedge clk);
      mr_n = 1'b1;
      count_while(1'b1, 2000, n);
      check_rng("R3 stretch after release", n, (S-1)*C, S*C+10);
    end

    // R6/R7/R8: timeout per select code
    for (int s = 0; s < 4; s++) begin
      lim = (s == 0) ? LA : (s == 1) ? LB : LC;
      kick_off();
      sel = 2'(s);
      falling();
      count_while(1'b0, (LC+20)*C, n);
      check_rng($sformatf("R6 timeout sel=%0d", s), n, (lim-1)*C, lim*C+8);
      count_while(1'b1, 2000, n);
      check_rng("R7 stretch after expiry", n, (S-1)*C, S*C+8);
      if (s == 0) begin
        count_while(1'b0, (LC+20)*C, n);
        check_rng("R8 fresh timeout after release", n, (lim-1)*C, lim*C+4);
        count_while(1'b1, 2000, n);
      end
      kick_en = 1'b1;
      repeat (4) @(negedge clk);
    end

    // R5: rising edge does not restart
    kick_off();
    sel = 2'b00;
    falling();
    repeat (100*C) @(negedge clk);
    man_s = 1'b1;
    count_while(1'b0, (LC+20)*C, n);
    check_rng("R5 rising edge ignored", n + 100*C, (LA-1)*C, LA*C+8);
    count_while(1'b1, 2000, n);

    // R5: falling edges restart
    falling();
    repeat (100*C) @(negedge clk);
    falling();
    repeat (100*C) @(negedge clk);
    falling();
    count_while(1'b0, (LC+20)*C, n);
    check_rng("R5 falling edge restarts", n, (LA-1)*C, LA*C+8);
    count_while(1'b1, 2000, n);
    kick_en = 1'b1;

    check(mism == 0, "R9 complement", mism, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  int lim_arr[1];
endmodule